// File: doc/BRIEF.md
# Cascadable Display Line Data Loader

The block gathers one horizontal line of 8-bit gray-scale values for a 384-channel column driver. Every rising clock edge of an active load carries 48 bits on the data bus, which is six gray values. A group counter steps through 64 load positions, so 64 edges fill the whole line. The direction input decides two things: which side the line is filled from, and which of the two start pins is the input and which is the cascade output.

Several drivers can be chained. A load begins on the edge where the selected start input is high. After 64 edges the block sends a one-cycle start pulse on the opposite pin, and that pulse starts the next driver in the chain. Two edges later, the loader halts by itself and ignores the bus until it sees a new start. A rising edge on the line strobe input ends any load still in progress. The line register keeps its contents so that later stages can convert them.

Each start pin is brought out as three signals: a separate input, a separate output and an output-enable. The enable is driven from the direction input, so no tri-state logic sits inside the block.

Top module: `line_capture`

## Requirements
- R1: In each bus word, dot j (j = 0..5) occupies bits [8j+7:8j], and bit 8j is the dot's LSB. Channel k (0-based) appears at line_out[8k+7:8k].
- R2: When dir_right = 1, start_r_in is the start input. Dot j of group g goes to channel 6g+j. The cascade pulse leaves on start_l_out. start_l_oe = 1 and start_r_oe = 0.
- R3: When dir_right = 0, start_l_in is the start input. Dot j of group g goes to channel 383-(6g+j), so the line fills in descending order. The cascade pulse leaves on start_r_out. start_r_oe = 1 and start_l_oe = 0.
- R4: A load starts on the rising edge where the selected start input is high, and the data on that same edge is group 0. A high level on the start input that is not selected has no effect.
- R5: The cascade output is high for exactly one cycle, directly after the 64th edge of the load. The start edge counts as the first edge. The other start output stays low.
- R6: Once the 66th edge of a load has passed, bus data is ignored and the line register holds its value until the next start.
- R7: A strobe rising edge ends the load in progress. Bus data after that edge is ignored, and that load sends no cascade pulse.
- R8: If a start and a strobe rising edge arrive on the same edge, the start wins: the load begins and that edge's data is written as group 0.
- R9: While reset is asserted and just after it, every channel reads zero and both start outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_right | input | 1 | 1: fill from the low channel upward; 0: fill from the top channel downward |
| start_r_in | input | 1 | Right-side start pin, input path |
| start_l_in | input | 1 | Left-side start pin, input path |
| start_r_out | output | 1 | Right-side start pin, output path (cascade pulse in left mode) |
| start_l_out | output | 1 | Left-side start pin, output path (cascade pulse in right mode) |
| start_r_oe | output | 1 | Output enable for the right-side start pin |
| start_l_oe | output | 1 | Output enable for the left-side start pin |
| data_in | input | 48 | Six 8-bit gray values per clock |
| strobe | input | 1 | Line strobe; its rising edge clears the load sequencer |
| line_out | output | 3072 | 384 gray values, channel k at bits [8k+7:8k] |

## Verification
The start of a new line and the strobe rising edge that clears the sequencer can land on the same clock edge. The bench forces this by raising the strobe exactly on the start edge of one load. It then judges the outcome by checking that the whole new line is written, that the cascade pulse comes on the 64th edge, and that group 0 holds that edge's data. A second case raises the strobe partway through a load. There the bench expects the untouched channels to keep the previous line's values and expects no cascade pulse.

// File: rtl/line_capture.sv
module line_capture #(
  parameter int CHANNELS   = 384,
  parameter int DOT_W      = 8,
  parameter int DOTS       = 6,
  parameter int CASCADE_AT = 64,
  parameter int HALT_AT    = 66
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dir_right,
  input  logic                         start_r_in,
  input  logic                         start_l_in,
  output logic                         start_r_out,
  output logic                         start_l_out,
  output logic                         start_r_oe,
  output logic                         start_l_oe,
  input  logic [DOTS*DOT_W-1:0]        data_in,
  input  logic                         strobe,
  output logic [CHANNELS*DOT_W-1:0]    line_out
);
  localparam int GROUPS = CHANNELS / DOTS;
  localparam int CW     = $clog2(HALT_AT + 1);

  logic          active_q, dir_q, casc_q, strobe_q;
  logic [CW-1:0] cnt_q;
  logic [CHANNELS*DOT_W-1:0] line_q;

  wire start_hit = dir_right ? start_r_in : start_l_in;
  wire clr       = strobe & ~strobe_q;
  wire wdir      = start_hit ? dir_right : dir_q;
  wire [CW-1:0] wgrp = start_hit ? '0 : cnt_q;
  wire wen       = start_hit | (active_q & ~clr & (cnt_q < CW'(GROUPS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_q    <= 1'b0;
      cnt_q    <= '0;
      casc_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
      casc_q   <= active_q & ~start_hit & ~clr & (cnt_q == CW'(CASCADE_AT - 1));
      if (start_hit) begin
        active_q <= 1'b1;
        cnt_q    <= CW'(1);
        dir_q    <= dir_right;
      end else if (clr) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (active_q) begin
        if (cnt_q == CW'(HALT_AT - 1)) active_q <= 1'b0;
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    localparam int GR = ch / DOTS;
    localparam int JR = ch % DOTS;
    localparam int GL = (CHANNELS - 1 - ch) / DOTS;
    localparam int JL = (CHANNELS - 1 - ch) % DOTS;
    wire hit = wen & (wdir ? (wgrp == CW'(GR)) : (wgrp == CW'(GL)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        line_q[ch*DOT_W +: DOT_W] <= '0;
      else if (hit)
        line_q[ch*DOT_W +: DOT_W] <= wdir ? data_in[JR*DOT_W +: DOT_W]
                                          : data_in[JL*DOT_W +: DOT_W];
    end
  end

  assign line_out    = line_q;
  assign start_l_oe  = dir_right;
  assign start_r_oe  = ~dir_right;
  assign start_l_out = casc_q & dir_q;
  assign start_r_out = casc_q & ~dir_q;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q |=> !casc_q);
  a_r5_pulse_position: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q |-> cnt_q == CW'(CASCADE_AT));
  a_r6_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q == CW'(HALT_AT - 1) && !start_hit && !clr) |=> !active_q);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start_hit) |=> $stable(line_q));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !start_hit) |=> (!active_q && cnt_q == '0));
  a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> (active_q && cnt_q == CW'(1)));
endmodule

// File: tb/line_capture_tb.sv
module line_capture_tb;
  localparam int CH = 384;
  logic clk = 1'b0, rst_n = 1'b0, dir_right = 1'b0;
  logic start_r_in = 1'b0, start_l_in = 1'b0, strobe = 1'b0;
  logic start_r_out, start_l_out, start_r_oe, start_l_oe;
  logic [47:0] data_in = '0;
  logic [CH*8-1:0] line_out;
  logic [7:0] model [CH];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  line_capture u_dut (.clk, .rst_n, .dir_right, .start_r_in, .start_l_in,
    .start_r_out, .start_l_out, .start_r_oe, .start_l_oe, .data_in, .strobe, .line_out);

  function automatic int chan(bit dr, int g, int j);
    return dr ? g*6 + j : CH - 1 - (g*6 + j);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_line(string req);
    int bad = -1;
    checks++;
    for (int k = 0; k < CH; k++)
      if (bad < 0 && line_out[k*8 +: 8] !== model[k]) bad = k;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: channel %0d actual %0h expected %0h", req, bad,
               line_out[bad*8 +: 8], model[bad]);
    end
  endtask

  // one load: start on edge 0, optional strobe rise at kill_at, 'edges' edges total
  task automatic run_line(bit dr, int edges, int kill_at, string req);
    bit alive = 1;
    dir_right = dr;
    start_r_in = 0; start_l_in = 0; strobe = 0;
    @(posedge clk); @(negedge clk);
    for (int e = 0; e < edges; e++) begin
      data_in = {$urandom, $urandom};
      if (dr) start_r_in = (e == 0); else start_l_in = (e == 0);
      strobe = (kill_at >= 0 && e >= kill_at);
      if (e == kill_at && e != 0) alive = 0;
      if (alive && e < 64)
        for (int j = 0; j < 6; j++) model[chan(dr, e, j)] = data_in[j*8 +: 8];
      @(posedge clk); @(negedge clk);
      chk({req, " R5 cascade"}, dr ? start_l_out : start_r_out, 64'(alive && e == 63));
      chk({req, " R5 idle pin"}, dr ? start_r_out : start_l_out, 64'd0);
    end
    start_r_in = 0; start_l_in = 0; strobe = 0;
    check_line(req);
  endtask

  task automatic wrong_pin(bit dr);
    dir_right = dr;
    for (int e = 0; e < 70; e++) begin
      data_in = {$urandom, $urandom};
      start_r_in = !dr; start_l_in = dr;
      @(posedge clk); @(negedge clk);
      chk("R4 wrong pin no cascade", 64'(start_l_out | start_r_out), 64'd0);
    end
    start_r_in = 0; start_l_in = 0;
    check_line("R4 wrong start pin ignored");
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < CH; k++) model[k] = 8'h00;
    repeat (3) @(negedge clk);
    check_line("R9 reset clears line");
    chk("R9 outputs low", {start_l_out, start_r_out}, 64'd0);
    chk("R3 oe left mode", {start_l_oe, start_r_oe}, 64'b01);
    rst_n = 1'b1;
    @(negedge clk);
    dir_right = 1'b1; @(negedge clk);
    chk("R2 oe right mode", {start_l_oe, start_r_oe}, 64'b10);
    // R1 directed: bus slice to channel with known dot values
    run_line(1, 66, -1, "R1 R2 right fill");
    chk("R1 channel 0 = dot0 of group0", line_out[7:0], model[0]);
    run_line(0, 66, -1, "R3 left fill");
    // R6: keep driving data well after the halt
    run_line(1, 90, -1, "R6 halt right");
    run_line(0, 90, -1, "R6 halt left");
    // R7: strobe rise mid-line
    run_line(1, 80, 20, "R7 strobe mid right");
    run_line(0, 80, 40, "R7 strobe mid left");
    // R8: strobe rise on the start edge
    run_line(1, 70, 0, "R8 start with strobe right");
    run_line(0, 70, 0, "R8 start with strobe left");
    // R4: the unselected pin is ignored
    wrong_pin(1);
    wrong_pin(0);
    // random lines
    for (int i = 0; i < 6; i++) begin
      int k = ($urandom % 3 == 0) ? 1 + int'($urandom % 70) : -1;
      run_line(1'($urandom), 70 + int'($urandom % 10), k, "R2 R3 R7 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule